// File: doc/BRIEF.md
# Binary Tape Bootstrap Loader

This block gives an 18-bit processor a way to fill its memory from eight-hole binary paper tape without any software in memory. A start pulse puts it in loading mode. The tape reader then presents one line per strobe. Each line carries eight hole bits, and a line counts only when its eighth hole is punched. Three counted lines form one 18-bit word.

The word stream alternates between command words and data words. A deposit command names an address, and the data word that follows is written there through a single-cycle memory write port. A jump command ends loading and sends out a one-cycle done pulse that carries the address where the loaded program should start. Any other command opcode stops loading and raises a sticky error flag. A new start pulse discards any partly assembled word, returns to the command phase and clears the error.

Top module: `tape_boot_loader`

## Requirements
- R1: After reset the block is idle. `mem_we_o`, `done_o` and `error_o` are low, and tape lines have no effect until a start pulse arrives.
- R2: A line is accepted only when `line_valid_i` is high and hole 8 (`line_holes_i[7]`) is punched. All other lines leave the assembly state unchanged. Hole 7 (`line_holes_i[6]`) never affects acceptance or data.
- R3: Holes 1 to 6 (`line_holes_i[5:0]`) give 6 bits, with hole 1 as the least significant bit. The first accepted line of a group supplies word bits [17:12], the second supplies [11:6] and the third supplies [5:0].
- R4: The first word after a start pulse is a command word. Command words and data words then alternate.
- R5: A command whose bits [17:13] equal 5'b01101 (deposit) sets the target address to bits [11:0]. When the next word completes, it is written to that address: `mem_we_o` is high for exactly one cycle, with `mem_addr_o` and `mem_data_o` valid.
- R6: A command whose bits [17:13] equal 5'b11000 (jump) raises `done_o` for one cycle, with `done_addr_o` set to bits [11:0]. After that, no further tape lines cause writes until the next start pulse.
- R7: A command with any other value in bits [17:13] sets `error_o`. The flag stays set until the next start pulse, and no writes occur while it is set.
- R8: A start pulse clears the line count, the command/data phase and the error flag, so a partly assembled word is discarded.
- R9: Bit 12 of a command word is ignored when the command is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse that begins or restarts loading |
| line_valid_i | input | 1 | Strobe marking that a tape line is present |
| line_holes_i | input | 8 | Hole bits; bit n-1 is hole n |
| mem_we_o | output | 1 | Memory write enable, one cycle per write |
| mem_addr_o | output | 12 | Memory write address |
| mem_data_o | output | 18 | Memory write data |
| done_o | output | 1 | One-cycle pulse when a jump command ends loading |
| done_addr_o | output | 12 | Start address reported by the jump command |
| error_o | output | 1 | Sticky flag for an illegal command |

## Verification
The assertions check the following on every cycle:
- Lines without hole 8 leave the line count unchanged.
- The line count stays in range, and hole 7 has no effect on acceptance.
- A start pulse empties the assembler.
- Writes are single-cycle, and a write never coincides with a done pulse.
- The error flag stays set, and no writes occur while it is set.
- After a jump, the block stays out of loading mode.

Other behaviour can only be shown by the bench scenarios:
- The order in which lines fill the word.
- The alternation between commands and data.
- The address and data carried by each write.
- The address reported by a jump.
- That a restart discards a partly assembled word.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  localparam int OPC_W = 5;
  localparam logic [OPC_W-1:0] OPC_DEPOSIT = 5'b01101;
  localparam logic [OPC_W-1:0] OPC_JUMP    = 5'b11000;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } load_state_e;
endpackage

// File: rtl/tbl_line_assembler.sv
module tbl_line_assembler #(
  parameter int LINE_BITS      = 6,
  parameter int LINES_PER_WORD = 3,
  localparam int WORD_W = LINE_BITS * LINES_PER_WORD,
  localparam int PART_W = WORD_W - LINE_BITS,
  localparam int CNT_W  = $clog2(LINES_PER_WORD)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enable_i,
  input  logic                 clear_i,
  input  logic                 line_valid_i,
  input  logic [LINE_BITS+1:0] line_holes_i,
  output logic                 word_valid_o,
  output logic [WORD_W-1:0]    word_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINES_PER_WORD - 1);

  logic [CNT_W-1:0]     cnt_q;
  logic [PART_W-1:0]    part_q;
  logic [LINE_BITS-1:0] bits;
  logic                 accept;

  // hole 8 gates the line, hole 7 is dropped
  assign accept = enable_i & line_valid_i & line_holes_i[LINE_BITS+1];
  assign bits   = line_holes_i[LINE_BITS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      part_q       <= '0;
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else if (clear_i) begin
      cnt_q        <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      if (accept) begin
        if (cnt_q == LAST) begin
          cnt_q        <= '0;
          word_o       <= {part_q, bits};
          word_valid_o <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          part_q <= {part_q[PART_W-LINE_BITS-1:0], bits};
        end
      end
    end
  end

  p_skip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(line_valid_i && line_holes_i[LINE_BITS+1])) |=> $stable(cnt_q));
  p_hole7_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !clear_i && line_valid_i && line_holes_i[LINE_BITS+1] && line_holes_i[LINE_BITS])
      |=> (cnt_q != $past(cnt_q) || word_valid_o));
  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0 && !word_valid_o));
endmodule

// File: rtl/tbl_cmd_sequencer.sv
module tbl_cmd_sequencer
  import tbl_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              loading_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] done_addr_o,
  output logic              error_o
);
  load_state_e       state_q;
  logic              is_data_q;
  logic [ADDR_W-1:0] target_q;
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] cmd_addr;

  assign opc       = word_i[WORD_W-1 -: OPC_W];
  assign cmd_addr  = word_i[ADDR_W-1:0];
  assign loading_o = (state_q == ST_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      is_data_q   <= 1'b0;
      target_q    <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_data_o  <= '0;
      done_o      <= 1'b0;
      done_addr_o <= '0;
      error_o     <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_LOAD;
      is_data_q <= 1'b0;
      mem_we_o  <= 1'b0;
      done_o    <= 1'b0;
      error_o   <= 1'b0;
    end else begin
      mem_we_o <= 1'b0;
      done_o   <= 1'b0;
      if (state_q == ST_LOAD && word_valid_i) begin
        if (is_data_q) begin
          mem_we_o   <= 1'b1;
          mem_addr_o <= target_q;
          mem_data_o <= word_i;
          is_data_q  <= 1'b0;
        end else begin
          unique case (opc)
            OPC_DEPOSIT: begin
              target_q  <= cmd_addr;
              is_data_q <= 1'b1;
            end
            OPC_JUMP: begin
              done_o      <= 1'b1;
              done_addr_o <= cmd_addr;
              state_q     <= ST_DONE;
            end
            default: begin
              error_o <= 1'b1;
              state_q <= ST_FAULT;
            end
          endcase
        end
      end
    end
  end

  p_single_we_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  p_we_not_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !done_o);
  p_done_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (!loading_o && !mem_we_o));
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> error_o);
  p_err_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !mem_we_o);
endmodule

// File: rtl/tape_boot_loader.sv
module tape_boot_loader #(
  parameter int LINE_BITS      = 6,
  parameter int LINES_PER_WORD = 3,
  parameter int ADDR_W         = 12,
  localparam int WORD_W = LINE_BITS * LINES_PER_WORD
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 line_valid_i,
  input  logic [LINE_BITS+1:0] line_holes_i,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [WORD_W-1:0]    mem_data_o,
  output logic                 done_o,
  output logic [ADDR_W-1:0]    done_addr_o,
  output logic                 error_o
);
  logic              loading;
  logic              word_valid;
  logic [WORD_W-1:0] word;

  tbl_line_assembler #(
    .LINE_BITS     (LINE_BITS),
    .LINES_PER_WORD(LINES_PER_WORD)
  ) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (loading),
    .clear_i     (start_i),
    .line_valid_i(line_valid_i),
    .line_holes_i(line_holes_i),
    .word_valid_o(word_valid),
    .word_o      (word)
  );

  tbl_cmd_sequencer #(
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .word_valid_i(word_valid),
    .word_i      (word),
    .loading_o   (loading),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .done_o      (done_o),
    .done_addr_o (done_addr_o),
    .error_o     (error_o)
  );
endmodule

// File: tb/tape_boot_loader_tb.sv
`timescale 1ns/1ps
module tape_boot_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        lvalid = 1'b0;
  logic [7:0]  holes = '0;
  logic        we;
  logic [11:0] addr;
  logic [17:0] data;
  logic        done;
  logic [11:0] done_addr;
  logic        err;

  int n_vec = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  logic [11:0] wr_addr = '0;
  logic [17:0] wr_data = '0;
  int done_cnt = 0;
  logic [11:0] done_seen = '0;

  always #2.5 clk = ~clk;

  tape_boot_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .line_valid_i(lvalid),
    .line_holes_i(holes), .mem_we_o(we), .mem_addr_o(addr), .mem_data_o(data),
    .done_o(done), .done_addr_o(done_addr), .error_o(err)
  );

  always @(negedge clk) begin
    if (rst_n && we) begin
      wr_cnt  <= wr_cnt + 1;
      wr_addr <= addr;
      wr_data <= data;
    end
    if (rst_n && done) begin
      done_cnt  <= done_cnt + 1;
      done_seen <= done_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_line(input logic [7:0] h);
    @(negedge clk);
    lvalid = 1'b1;
    holes  = h;
    @(negedge clk);
    lvalid = 1'b0;
    holes  = '0;
  endtask

  task automatic send_word(input logic [17:0] w, input bit junk, input logic [7:0] junk_h, input bit h7);
    for (int k = 0; k < 3; k++) begin
      if (junk) send_line(junk_h & 8'h7f);
      send_line({1'b1, h7, w[17-6*k -: 6]});
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [17:0] cmd(input logic [4:0] op, input bit ind, input logic [11:0] a);
    return {op, ind, a};
  endfunction

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int base;
    logic [17:0] d;
    logic [11:0] a;
    repeat (3) @(negedge clk);
    chk(!we && !done && !err, "R1 reset outputs", {we, done, err}, 0);
    rst_n = 1'b1;
    send_word(cmd(5'b01101, 0, 12'h123), 0, 0, 0);
    send_word(18'h3ffff, 0, 0, 0);
    settle();
    chk(wr_cnt == 0 && !err && done_cnt == 0, "R1 idle ignores lines", wr_cnt, 0);

    // sweep all 256 hole patterns as junk lines and hole-7 values
    pulse_start();
    for (int p = 0; p < 256; p++) begin
      base = wr_cnt;
      a = 12'((p * 16 + 3) % 4096);
      d = {6'(p) ^ 6'h15, 6'(p), ~6'(p)};
      send_word(cmd(5'b01101, p[0], a), p[7] == 1'b0, 8'(p), p[6]);
      send_word(d, p[7] == 1'b0, 8'(p), p[6]);
      settle();
      chk(wr_cnt == base + 1, "R5 R4 R9 write count", wr_cnt, base + 1);
      chk(wr_addr == a, "R5 write address", wr_addr, a);
      chk(wr_data == d, "R3 R2 write data", wr_data, d);
    end

    // jump terminates
    send_word(cmd(5'b11000, 0, 12'hA5C), 0, 0, 0);
    settle();
    chk(done_cnt == 1, "R6 done pulse count", done_cnt, 1);
    chk(done_seen == 12'hA5C, "R6 done address", done_seen, 12'hA5C);
    chk(!done, "R6 done is a pulse", done, 0);
    base = wr_cnt;
    send_word(cmd(5'b01101, 0, 12'h010), 0, 0, 0);
    send_word(18'h12345, 0, 0, 0);
    settle();
    chk(wr_cnt == base && done_cnt == 1, "R6 no load after jump", wr_cnt, base);

    // illegal command
    pulse_start();
    send_word(cmd(5'b00001, 0, 12'h020), 0, 0, 0);
    settle();
    chk(err == 1'b1, "R7 error raised", err, 1);
    send_word(cmd(5'b01101, 0, 12'h030), 0, 0, 0);
    send_word(18'h0abcd, 0, 0, 0);
    settle();
    chk(err == 1'b1 && wr_cnt == base, "R7 sticky, no write", wr_cnt, base);
    pulse_start();
    chk(err == 1'b0, "R8 start clears error", err, 0);

    // restart discards a partial word and the data phase
    send_word(cmd(5'b01101, 0, 12'h777), 0, 0, 0);
    send_line(8'h80 | 8'h3f);
    send_line(8'h80 | 8'h3f);
    pulse_start();
    send_word(cmd(5'b01101, 1, 12'h456), 0, 0, 0);
    send_word(18'h2b0c1, 0, 0, 0);
    settle();
    chk(wr_cnt == base + 1, "R8 one write after restart", wr_cnt, base + 1);
    chk(wr_addr == 12'h456, "R8 address from new command", wr_addr, 12'h456);
    chk(wr_data == 18'h2b0c1, "R8 clean word", wr_data, 18'h2b0c1);

    // jump with bit 12 set still recognised
    send_word(cmd(5'b11000, 1, 12'h001), 0, 0, 0);
    settle();
    chk(done_cnt == 2 && done_seen == 12'h001, "R9 R6 jump with bit 12", done_seen, 12'h001);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule